// File: doc/BRIEF.md
# Power-Up Store Checksum Validator

This block sits between a host and a 4096-byte byte-wide nonvolatile store. After reset it reads the whole store once. It folds bytes 4 and up into a CRC-32 and collects bytes 0 to 3 as the stored checksum word. It then takes one of four actions:

- If the payload CRC equals the CRC of an all-zero payload, the store counts as uninitialised. The block writes a built-in default configuration image, reads the payload again and seals the store with the new CRC.
- If the payload is not blank and the stored word is zero, the block writes the computed CRC into the word.
- If the stored word is nonzero and differs from the computed CRC, the block flags a mismatch and leaves the store untouched.
- If the stored word matches the computed CRC, the block does nothing.

Once the check ends, `chk_done` rises and the host port is connected straight to the store, one byte per access. Until then the host is held off with `h_ready` low.

Top module: `nvck_top`

## Requirements
- R1: In the cycle after reset is released, `chk_busy`=1, `chk_done`=0, `chk_bad`=0 and `h_ready`=0. Host reads and writes made while `h_ready`=0 reach neither the store nor `h_rvalid`.
- R2: The check reads every store address from 0 to 4095. The CRC is the reflected CRC-32 over bytes 4..4095, with polynomial 0xEDB88320, start value 0xFFFFFFFF and final inversion. The stored word is big-endian: byte 0 holds bits 31:24.
- R3: When the payload CRC equals 0x603B0489, the block writes the 41-byte default image to offsets 4..44. The image is "speed=57600", "con=serial", "boot=disk" and "wait=2", each followed by a zero byte, plus one extra zero byte. The block then writes the CRC of the resulting payload into bytes 0..3, big-endian. That is 45 store writes, and `chk_bad` stays 0.
- R4: When the payload is not blank and the stored word is zero, the block writes the computed CRC into bytes 0..3, big-endian (4 writes). The payload is left unchanged and `chk_bad` stays 0.
- R5: When the stored word is nonzero and differs from the computed CRC, `chk_bad` rises together with `chk_done` and the store receives no write.
- R6: When the stored word equals the computed CRC, the store receives no write and `chk_bad` stays 0.
- R7: `chk_done` stays 1 until the next reset, `chk_busy` is always its inverse, and `chk_bad` does not change once `chk_done` is 1.
- R8: After `chk_done`, a host write reaches the store in the same cycle. A host read returns the store byte with `h_rvalid`=1 one cycle after the request. A request that has both read and write set acts as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 12 | Host byte address |
| h_rd | input | 1 | Host read request |
| h_wr | input | 1 | Host write request |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte |
| h_rvalid | output | 1 | Host read byte valid |
| h_ready | output | 1 | Host port open |
| st_addr | output | 12 | Store byte address |
| st_rd | output | 1 | Store read strobe (data next cycle) |
| st_wr | output | 1 | Store write strobe |
| st_wdata | output | 8 | Store write byte |
| st_rdata | input | 8 | Store read byte |
| chk_busy | output | 1 | Power-up check running |
| chk_done | output | 1 | Power-up check finished |
| chk_bad | output | 1 | Stored checksum mismatch |

## Verification
Four preloaded store images are used, and each drives a different branch of the decision:

- A zeroed payload under a nonzero junk word must take the restore path. This path needs a second scan, and the seal value has to be computed over the freshly written image.
- A patterned payload under a zero word must take the self-seal path, with the payload unchanged.
- The same payload with one flipped bit in its word must raise the mismatch flag and cause no writes.
- The same payload with the correct word must cause no action at all.

Each image is checked byte for byte against a CRC model in the bench. A host write is also attempted during the check, to show that it is held off. Host reads and writes after the check confirm the pass-through port.

// File: rtl/nvck_pkg.sv
package nvck_pkg;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam int HDR_BYTES = 4;

    // default configuration image: zero-terminated key=value strings, double zero at end
    localparam int IMG_LEN = 41;
    localparam logic [IMG_LEN*8-1:0] IMG_BITS = {
        "speed=57600", 8'h00,
        "con=serial",  8'h00,
        "boot=disk",   8'h00,
        "wait=2",      8'h00,
        8'h00
    };

    typedef enum logic [2:0] {
        PH_SCAN,
        PH_JUDGE,
        PH_FILL,
        PH_SEAL,
        PH_OPEN
    } phase_e;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] img_byte(input int idx);
        if (idx < 0 || idx >= IMG_LEN) return 8'h00;
        return IMG_BITS[(IMG_LEN-1-idx)*8 +: 8];
    endfunction

endpackage

// File: rtl/nvck_crc_acc.sv
module nvck_crc_acc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_o
);
    import nvck_pkg::*;

    logic [31:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = 32'hFFFF_FFFF;
        end else if (en) begin
            acc_d = crc_step(acc_q, din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= 32'hFFFF_FFFF;
        else        acc_q <= acc_d;
    end

    assign crc_o = ~acc_q;

endmodule

// File: rtl/nvck_ctrl.sv
module nvck_ctrl #(
    parameter int          ST_BYTES  = 4096,
    parameter logic [31:0] BLANK_CRC = 32'h603B0489,
    localparam int         AW        = $clog2(ST_BYTES),
    localparam int         CW        = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    st_rdata,
    input  logic [31:0]   crc_val,
    output logic [AW-1:0] c_addr,
    output logic          c_rd,
    output logic          c_wr,
    output logic [7:0]    c_wdata,
    output logic          crc_clr,
    output logic          crc_en,
    output logic          busy,
    output logic          done,
    output logic          bad
);
    import nvck_pkg::*;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          pend;
        logic [AW-1:0] paddr;
        logic [31:0]   word;
        logic          refilled;
        logic          bad;
        logic          done;
    } ctrl_t;

    ctrl_t q, d;

    localparam logic [CW-1:0] SCAN_END = CW'(ST_BYTES);
    localparam logic [CW-1:0] FILL_END = CW'(IMG_LEN - 1);
    localparam logic [AW-1:0] LAST_ADR = AW'(ST_BYTES - 1);
    localparam logic [AW-1:0] HDR_ADR  = AW'(HDR_BYTES);

    always_comb begin
        d       = q;
        d.pend  = 1'b0;
        c_addr  = '0;
        c_rd    = 1'b0;
        c_wr    = 1'b0;
        c_wdata = 8'h00;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        unique case (q.phase)
            PH_SCAN: begin
                if (q.cnt < SCAN_END) begin
                    c_rd    = 1'b1;
                    c_addr  = q.cnt[AW-1:0];
                    d.pend  = 1'b1;
                    d.paddr = q.cnt[AW-1:0];
                    d.cnt   = q.cnt + CW'(1);
                end
                if (q.pend) begin
                    if (q.paddr < HDR_ADR) d.word = {q.word[23:0], st_rdata};
                    else                   crc_en = 1'b1;
                    if (q.paddr == LAST_ADR) d.phase = PH_JUDGE;
                end
            end
            PH_JUDGE: begin
                d.cnt = '0;
                if (q.refilled) begin
                    d.phase = PH_SEAL;
                end else if (crc_val == BLANK_CRC) begin
                    d.phase    = PH_FILL;
                    d.refilled = 1'b1;
                end else if (q.word == 32'h0) begin
                    d.phase = PH_SEAL;
                end else begin
                    d.phase = PH_OPEN;
                    d.done  = 1'b1;
                    d.bad   = (q.word != crc_val);
                end
            end
            PH_FILL: begin
                c_wr    = 1'b1;
                c_addr  = HDR_ADR + q.cnt[AW-1:0];
                c_wdata = img_byte(int'(q.cnt));
                if (q.cnt == FILL_END) begin
                    d.phase = PH_SCAN;
                    d.cnt   = '0;
                    crc_clr = 1'b1;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            PH_SEAL: begin
                c_wr   = 1'b1;
                c_addr = q.cnt[AW-1:0];
                unique case (q.cnt[1:0])
                    2'd0:    c_wdata = crc_val[31:24];
                    2'd1:    c_wdata = crc_val[23:16];
                    2'd2:    c_wdata = crc_val[15:8];
                    default: c_wdata = crc_val[7:0];
                endcase
                if (q.cnt[1:0] == 2'd3) begin
                    d.phase = PH_OPEN;
                    d.done  = 1'b1;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: begin
                d.phase = PH_OPEN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase    <= PH_SCAN;
            q.cnt      <= '0;
            q.pend     <= 1'b0;
            q.paddr    <= '0;
            q.word     <= '0;
            q.refilled <= 1'b0;
            q.bad      <= 1'b0;
            q.done     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.phase != PH_OPEN);
    assign done = q.done;
    assign bad  = q.bad;

endmodule

// File: rtl/nvck_top.sv
module nvck_top #(
    parameter int          ST_BYTES  = 4096,
    parameter logic [31:0] BLANK_CRC = 32'h603B0489,
    localparam int         AW        = $clog2(ST_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] h_addr,
    input  logic          h_rd,
    input  logic          h_wr,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    output logic          h_rvalid,
    output logic          h_ready,
    output logic [AW-1:0] st_addr,
    output logic          st_rd,
    output logic          st_wr,
    output logic [7:0]    st_wdata,
    input  logic [7:0]    st_rdata,
    output logic          chk_busy,
    output logic          chk_done,
    output logic          chk_bad
);
    logic [AW-1:0] c_addr;
    logic          c_rd, c_wr;
    logic [7:0]    c_wdata;
    logic          crc_clr, crc_en;
    logic [31:0]   crc_val;
    logic          rv_d, rv_q;

    nvck_crc_acc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (st_rdata),
        .crc_o (crc_val)
    );

    nvck_ctrl #(
        .ST_BYTES  (ST_BYTES),
        .BLANK_CRC (BLANK_CRC)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_rdata (st_rdata),
        .crc_val  (crc_val),
        .c_addr   (c_addr),
        .c_rd     (c_rd),
        .c_wr     (c_wr),
        .c_wdata  (c_wdata),
        .crc_clr  (crc_clr),
        .crc_en   (crc_en),
        .busy     (chk_busy),
        .done     (chk_done),
        .bad      (chk_bad)
    );

    always_comb begin
        if (chk_done) begin
            st_addr  = h_addr;
            st_wr    = h_wr;
            st_rd    = h_rd & ~h_wr;
            st_wdata = h_wdata;
        end else begin
            st_addr  = c_addr;
            st_wr    = c_wr;
            st_rd    = c_rd;
            st_wdata = c_wdata;
        end
        rv_d = chk_done & h_rd & ~h_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rv_q <= 1'b0;
        else        rv_q <= rv_d;
    end

    assign h_ready  = chk_done;
    assign h_rvalid = rv_q;
    assign h_rdata  = st_rdata;

endmodule

// File: rtl/nvck_chk.sv
module nvck_chk (
    input logic clk,
    input logic rst_n,
    input logic h_rd,
    input logic h_wr,
    input logic h_ready,
    input logic h_rvalid,
    input logic st_rd,
    input logic st_wr,
    input logic chk_busy,
    input logic chk_done,
    input logic chk_bad
);
    AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        chk_busy |-> !h_ready); // R1
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |=> chk_done); // R7
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        chk_busy != chk_done); // R7
    AST_BAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |=> $stable(chk_bad)); // R7
    AST_BAD_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_bad |-> chk_done); // R5
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_rd && st_wr)); // R8
    AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        h_rvalid |-> $past(h_rd && !h_wr && h_ready)); // R8
    AST_WRITE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ready && h_wr) |-> st_wr); // R8
endmodule

bind nvck_top nvck_chk u_nvck_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_rd     (h_rd),
    .h_wr     (h_wr),
    .h_ready  (h_ready),
    .h_rvalid (h_rvalid),
    .st_rd    (st_rd),
    .st_wr    (st_wr),
    .chk_busy (chk_busy),
    .chk_done (chk_done),
    .chk_bad  (chk_bad)
);

// File: tb/test_nvck_top.sv
`timescale 1ns/1ps
module test_nvck_top;
    localparam int N = 4096;
    localparam int ILEN = 41;
    localparam logic [ILEN*8-1:0] DEF_IMG = {
        "speed=57600", 8'h00, "con=serial", 8'h00,
        "boot=disk", 8'h00, "wait=2", 8'h00, 8'h00
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] h_addr = '0;
    logic h_rd = 1'b0, h_wr = 1'b0;
    logic [7:0] h_wdata = '0;
    logic [7:0] h_rdata;
    logic h_rvalid, h_ready;
    logic [11:0] st_addr;
    logic st_rd, st_wr;
    logic [7:0] st_wdata;
    logic [7:0] st_rdata = '0;
    logic chk_busy, chk_done, chk_bad;

    int total = 0, bad = 0;
    int busy_writes = 0;
    int cycles = 0;

    logic [7:0] mem [N];
    logic [7:0] expm [N];
    logic [7:0] sb_q [$];
    string      sb_tag [$];

    always #2.5 clk = ~clk;

    nvck_top i_nvck_top (
        .clk(clk), .rst_n(rst_n),
        .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_rvalid(h_rvalid), .h_ready(h_ready),
        .st_addr(st_addr), .st_rd(st_rd), .st_wr(st_wr),
        .st_wdata(st_wdata), .st_rdata(st_rdata),
        .chk_busy(chk_busy), .chk_done(chk_done), .chk_bad(chk_bad)
    );

    // backing store model: synchronous read, one cycle latency
    always @(posedge clk) begin
        if (st_wr) mem[st_addr] <= st_wdata;
        if (st_rd) st_rdata <= mem[st_addr];
        if (rst_n && st_wr && chk_busy) busy_writes <= busy_writes + 1;
        cycles <= cycles + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && h_rvalid) begin
            if (sb_q.size() == 0) begin
                check("R1 unexpected h_rvalid", 32'(h_rvalid), 32'd0);
            end else begin
                automatic logic [7:0] e = sb_q.pop_front();
                automatic string t = sb_tag.pop_front();
                check(t, 32'(h_rdata), 32'(e));
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 190000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] ref_crc();
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 4; i < N; i++) begin
            c = c ^ {24'h0, expm[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic set_word(input logic [31:0] w);
        expm[0] = w[31:24]; expm[1] = w[23:16]; expm[2] = w[15:8]; expm[3] = w[7:0];
    endtask

    task automatic load_pattern();
        for (int i = 4; i < N; i++) expm[i] = 8'((i * 7 + 3) ^ (i >> 5));
    endtask

    task automatic copy_to_store();
        for (int i = 0; i < N; i++) mem[i] = expm[i];
    endtask

    // reset, then run; optionally poke host during busy
    task automatic start_case(input string tag, input bit poke);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        busy_writes = 0;
        rst_n = 1'b1;
        @(negedge clk);
        check({tag, " R1 reset busy/done/bad/ready"},
              {28'h0, chk_busy, chk_done, chk_bad, h_ready}, 32'h8);
        if (poke) begin
            h_addr = 12'd200; h_wdata = 8'hAA; h_wr = 1'b1; h_rd = 1'b1;
            @(negedge clk);
            h_wr = 1'b0; h_rd = 1'b0;
        end
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!chk_done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check({tag, " R2 check finished"}, 32'(chk_done), 32'd1);
    endtask

    task automatic compare_store(input string tag);
        int errs = 0, first = -1;
        for (int i = 0; i < N; i++) if (mem[i] !== expm[i]) begin
            errs++;
            if (first < 0) first = i;
        end
        if (first < 0) check(tag, 32'd0, 32'd0);
        else check({tag, $sformatf(" byte %0d", first)}, 32'(mem[first]), 32'(expm[first]));
    endtask

    task automatic host_write(input logic [11:0] a, input logic [7:0] v);
        h_addr = a; h_wdata = v; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0;
        check("R8 host write reaches store", 32'(mem[a]), 32'(v));
        expm[a] = v;
    endtask

    task automatic host_read(input logic [11:0] a, input string tag);
        sb_q.push_back(expm[a]);
        sb_tag.push_back(tag);
        h_addr = a; h_rd = 1'b1;
        @(negedge clk);
        h_rd = 1'b0;
    endtask

    initial begin
        logic [31:0] c;
        logic bad_seen;

        // ---------- blank store (R3) ----------
        for (int i = 0; i < N; i++) expm[i] = 8'h00;
        check("R2 reference blank crc", ref_crc(), 32'h603B0489);
        set_word(32'h1234_5678);
        copy_to_store();
        start_case("blank", 1'b0);
        wait_done("blank");
        for (int i = 0; i < ILEN; i++) expm[4+i] = DEF_IMG[(ILEN-1-i)*8 +: 8];
        c = ref_crc();
        set_word(c);
        compare_store("R3 blank restore+seal contents");
        check("R3 blank write count", 32'(busy_writes), 32'(ILEN + 4));
        check("R3 blank bad flag", 32'(chk_bad), 32'd0);

        // ---------- zero checksum word (R4) ----------
        load_pattern();
        set_word(32'h0);
        copy_to_store();
        start_case("zeroword", 1'b0);
        wait_done("zeroword");
        set_word(ref_crc());
        compare_store("R4 self-seal contents");
        check("R4 self-seal write count", 32'(busy_writes), 32'd4);
        check("R4 self-seal bad flag", 32'(chk_bad), 32'd0);

        // ---------- corrupted word (R5) ----------
        load_pattern();
        set_word(ref_crc() ^ 32'h0000_0100);
        copy_to_store();
        start_case("corrupt", 1'b0);
        wait_done("corrupt");
        compare_store("R5 mismatch leaves contents");
        check("R5 mismatch write count", 32'(busy_writes), 32'd0);
        check("R5 mismatch bad flag", 32'(chk_bad), 32'd1);
        bad_seen = chk_bad;
        repeat (10) @(negedge clk);
        check("R7 done/busy/bad held", {29'h0, chk_done, chk_busy, chk_bad}, {29'h0, 1'b1, 1'b0, bad_seen});

        // ---------- good store, host poked during busy (R6, R1) ----------
        load_pattern();
        set_word(ref_crc());
        copy_to_store();
        start_case("good", 1'b1);
        wait_done("good");
        check("R1 busy host write ignored", 32'(mem[200]), 32'(expm[200]));
        compare_store("R6 match leaves contents");
        check("R6 match write count", 32'(busy_writes), 32'd0);
        check("R6 match bad flag", 32'(chk_bad), 32'd0);

        // ---------- host port after done (R8) ----------
        host_write(12'd300, 8'h5C);
        host_read(12'd300, "R8 read back written byte");
        host_read(12'd0, "R8 read checksum byte 0");
        host_read(12'd4000, "R8 read payload byte");
        h_addr = 12'd301; h_wdata = 8'h3E; h_wr = 1'b1; h_rd = 1'b1;
        @(negedge clk);
        h_wr = 1'b0; h_rd = 1'b0;
        check("R8 rd+wr acts as write", 32'(mem[301]), 32'h3E);
        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", 32'(sb_q.size()), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule